// File: doc/BRIEF.md
# Region-Aware DMA/CPU Bus Arbiter

This block decides, on every clock, which of two masters may use the memory system: a CPU port issuing single accesses and a DMA port running handshaked transfer cycles. Every request carries a 2-bit region code. The DMA request carries two codes, one for the region it reads and one for the region it writes. The DMA side has priority. The CPU is not locked out while a transfer runs, though. It keeps running while its target is an internal memory that the current transfer does not touch. It is stalled when it targets the shared system path or a memory that the transfer is using.

A DMA cycle starts when the arbiter accepts a request. It ends on the edge that samples the done strobe. That same edge is a free decision point: a DMA request waiting there can start the next cycle at once. A starvation counter caps how many stalling DMA cycles can pass a waiting CPU back to back.

Top module: `bus_region_arb`

## Requirements
- R1: While rst_ni is low, cpu_gnt_o, cpu_wait_o, dma_gnt_o, dma_wait_o and busy_o are all 0.
- R2: The edge after dma_req_i is sampled at a free edge sets dma_gnt_o. The grant stays high until the edge that samples dma_done_i = 1, and it is low after that edge unless a new request is accepted there.
- R3: When both ports request at a free edge and the CPU region conflicts with the new transfer, the DMA port is granted and the CPU gets cpu_wait_o. This holds unless R8 applies.
- R4: Region codes are 00 internal ROM, 01 internal RAM, 10 peripheral I/O, 11 external memory. A CPU access with code 10 or 11 sampled during a DMA cycle is never granted.
- R5: A CPU access to code 00 or 01 that equals neither the DMA source nor the DMA destination is granted in the cycle after it is sampled, even while a DMA cycle runs. Examples: ROM or RAM during an external↔peripheral transfer, and ROM during a peripheral↔RAM transfer.
- R6: A CPU access to code 00 or 01 that equals the DMA source or the DMA destination of the running cycle is stalled.
- R7: A stalled CPU access is granted in the cycle after the edge that samples dma_done_i, provided dma_req_i is low at that edge. If dma_req_i is high there and the CPU conflicts with the new transfer, the CPU keeps waiting.
- R8: After 8 DMA cycles in a row that were accepted over a waiting, conflicting CPU, the next free edge grants the CPU. At that edge the DMA request is held off and dma_wait_o is 1. The DMA request is accepted on the edge after.
- R9: busy_o is 1 exactly while a DMA cycle is in progress, from the cycle after acceptance through the cycle whose closing edge samples done.
- R10: cpu_wait_o is 1 when the CPU request was sampled but not granted. dma_wait_o is 1 when a DMA request was sampled at a free edge but not accepted. A wait and the matching grant are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request, held until granted |
| cpu_region_i | input | 2 | CPU target region code |
| dma_req_i | input | 1 | DMA cycle request, held until granted |
| dma_src_i | input | 2 | Region the DMA cycle reads |
| dma_dst_i | input | 2 | Region the DMA cycle writes |
| dma_done_i | input | 1 | One-cycle strobe ending the current DMA cycle |
| cpu_gnt_o | output | 1 | CPU access proceeds this cycle |
| cpu_wait_o | output | 1 | CPU request is stalled |
| dma_gnt_o | output | 1 | DMA owns its regions for the current cycle |
| dma_wait_o | output | 1 | DMA request held off at a decision edge |
| busy_o | output | 1 | A DMA cycle is in progress |

## Verification
The hardest state to reach is the starvation release. Getting there takes nine DMA cycles chained back to back, each one arriving on the very edge that ends the previous cycle, while a conflicting CPU request is held the whole time. The bench drives the done strobe and the next request in the same cycle, eight times over, and then checks that the ninth chained request loses to the CPU and starts one edge later. The conflict rules are covered by a full sweep over all 64 combinations of source, destination and CPU region. The sweep runs both for a CPU request arriving mid-transfer and for a CPU request colliding with a new transfer at a free edge.

// File: rtl/bra_pkg.sv
package bra_pkg;
  typedef logic [1:0] region_t;

  localparam region_t RGN_ROM = 2'b00;
  localparam region_t RGN_RAM = 2'b01;
  localparam region_t RGN_PIO = 2'b10;
  localparam region_t RGN_EXT = 2'b11;

  // peripheral I/O and external memory ride the shared system path
  function automatic logic on_system_path(region_t r);
    return (r == RGN_PIO) || (r == RGN_EXT);
  endfunction
endpackage

// File: rtl/bra_conflict.sv
module bra_conflict
  import bra_pkg::*;
(
  input  region_t cpu_rgn_i,
  input  region_t src_i,
  input  region_t dst_i,
  output logic    conflict_o
);
  logic touches_path;

  always_comb begin
    touches_path = (cpu_rgn_i == src_i) || (cpu_rgn_i == dst_i);
    conflict_o   = on_system_path(cpu_rgn_i) || touches_path;
  end
endmodule

// File: rtl/bra_dma_slot.sv
module bra_dma_slot
  import bra_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    accept_i,
  input  logic    done_i,
  input  region_t src_i,
  input  region_t dst_i,
  output logic    active_o,
  output logic    live_o,
  output region_t src_o,
  output region_t dst_o
);
  logic    active_q;
  region_t src_q, dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      src_q    <= RGN_ROM;
      dst_q    <= RGN_ROM;
    end else if (accept_i) begin
      active_q <= 1'b1;
      src_q    <= src_i;
      dst_q    <= dst_i;
    end else if (done_i) begin
      active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign live_o   = active_q && !done_i;
  assign src_o    = src_q;
  assign dst_o    = dst_q;

  // a running cycle must never be overwritten
  p_no_accept_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !done_i |-> !accept_i);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !done_i |=> active_q && $stable(src_q) && $stable(dst_q));
endmodule

// File: rtl/bra_starve_ctr.sv
module bra_starve_ctr #(
  parameter int LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (inc_i && !at_limit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == CW'(LIMIT));

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));
  p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && inc_i && !at_limit_o |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/bus_region_arb.sv
module bus_region_arb
  import bra_pkg::*;
#(
  parameter int STARVE_LIMIT = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpu_req_i,
  input  logic [1:0] cpu_region_i,
  input  logic       dma_req_i,
  input  logic [1:0] dma_src_i,
  input  logic [1:0] dma_dst_i,
  input  logic       dma_done_i,
  output logic       cpu_gnt_o,
  output logic       cpu_wait_o,
  output logic       dma_gnt_o,
  output logic       dma_wait_o,
  output logic       busy_o
);
  localparam int NCHK = 2;  // 0: running cycle, 1: incoming request

  logic    active, live, free_edge;
  region_t lat_src, lat_dst;
  region_t chk_src [NCHK];
  region_t chk_dst [NCHK];
  logic    conf    [NCHK];
  logic    at_limit, starve_win, dma_accept, cpu_ok, stall_inc;
  logic    cpu_gnt_q, cpu_wait_q, dma_wait_q;

  assign chk_src[0] = lat_src;
  assign chk_dst[0] = lat_dst;
  assign chk_src[1] = dma_src_i;
  assign chk_dst[1] = dma_dst_i;

  for (genvar g = 0; g < NCHK; g++) begin : g_conf
    bra_conflict u_conf (
      .cpu_rgn_i (cpu_region_i),
      .src_i     (chk_src[g]),
      .dst_i     (chk_dst[g]),
      .conflict_o(conf[g])
    );
  end

  bra_dma_slot u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(dma_accept),
    .done_i  (dma_done_i),
    .src_i   (dma_src_i),
    .dst_i   (dma_dst_i),
    .active_o(active),
    .live_o  (live),
    .src_o   (lat_src),
    .dst_o   (lat_dst)
  );

  always_comb begin
    free_edge  = !live;
    starve_win = free_edge && dma_req_i && cpu_req_i && conf[1] && at_limit;
    dma_accept = free_edge && dma_req_i && !starve_win;
    if (live)            cpu_ok = cpu_req_i && !conf[0];
    else if (dma_accept) cpu_ok = cpu_req_i && !conf[1];
    else                 cpu_ok = cpu_req_i;
    stall_inc  = dma_accept && cpu_req_i && conf[1];
  end

  bra_starve_ctr #(.LIMIT(STARVE_LIMIT)) u_starve (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (!cpu_req_i || cpu_ok),
    .inc_i     (stall_inc),
    .at_limit_o(at_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_gnt_q  <= 1'b0;
      cpu_wait_q <= 1'b0;
      dma_wait_q <= 1'b0;
    end else begin
      cpu_gnt_q  <= cpu_ok;
      cpu_wait_q <= cpu_req_i && !cpu_ok;
      dma_wait_q <= free_edge && dma_req_i && !dma_accept;
    end
  end

  assign cpu_gnt_o  = cpu_gnt_q;
  assign cpu_wait_o = cpu_wait_q;
  assign dma_gnt_o  = active;
  assign dma_wait_o = dma_wait_q;
  assign busy_o     = active;

  p_gnt_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_gnt_o && dma_done_i && !dma_req_i |=> !dma_gnt_o);
  p_dma_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_gnt_o || dma_done_i) && dma_req_i && !cpu_req_i |=> dma_gnt_o);
  p_path_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_gnt_o && !dma_done_i && cpu_req_i && cpu_region_i[1] |=> !cpu_gnt_o);
  p_done_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_gnt_o && dma_done_i && !dma_req_i && cpu_req_i |=> cpu_gnt_o);
  p_cpu_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_gnt_o && cpu_wait_o));
  p_dma_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dma_gnt_o && dma_wait_o) || $past(dma_req_i));
endmodule

// File: tb/tb_bus_region_arb.sv
module tb_bus_region_arb;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_req_i = 1'b0;
  logic [1:0] cpu_region_i = 2'b00;
  logic dma_req_i = 1'b0;
  logic [1:0] dma_src_i = 2'b00;
  logic [1:0] dma_dst_i = 2'b00;
  logic dma_done_i = 1'b0;
  logic cpu_gnt_o, cpu_wait_o, dma_gnt_o, dma_wait_o, busy_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_region_arb #(.STARVE_LIMIT(8)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_region_i(cpu_region_i),
    .dma_req_i(dma_req_i), .dma_src_i(dma_src_i), .dma_dst_i(dma_dst_i),
    .dma_done_i(dma_done_i),
    .cpu_gnt_o(cpu_gnt_o), .cpu_wait_o(cpu_wait_o),
    .dma_gnt_o(dma_gnt_o), .dma_wait_o(dma_wait_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // conflict per R4/R5/R6: codes 10/11 always, else equality with source or destination
  function automatic logic conf(input int c, input int s, input int d);
    return (c >= 2) || (c == s) || (c == d);
  endfunction

  function automatic string rtag(input int c, input logic cf);
    if (c >= 2) return "R4";
    return cf ? "R6" : "R5";
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "cpu_gnt", cpu_gnt_o, 1'b0);
    chk("R1", "cpu_wait", cpu_wait_o, 1'b0);
    chk("R1", "dma_gnt", dma_gnt_o, 1'b0);
    chk("R1", "dma_wait", dma_wait_o, 1'b0);
    chk("R1", "busy", busy_o, 1'b0);
    rst_ni = 1'b1;

    // CPU request arriving in the middle of a DMA cycle
    for (int s = 0; s < 4; s++) for (int d = 0; d < 4; d++) for (int c = 0; c < 4; c++) begin
      logic cf;
      cf = conf(c, s, d);
      @(negedge clk_i);
      dma_req_i = 1'b1; dma_src_i = 2'(s); dma_dst_i = 2'(d);
      @(negedge clk_i);
      chk("R2", "dma_gnt on accept", dma_gnt_o, 1'b1);
      chk("R9", "busy on accept", busy_o, 1'b1);
      dma_req_i = 1'b0; cpu_req_i = 1'b1; cpu_region_i = 2'(c);
      @(negedge clk_i);
      chk(rtag(c, cf), "cpu_gnt mid-cycle", cpu_gnt_o, !cf);
      chk("R10", "cpu_wait mid-cycle", cpu_wait_o, cf);
      chk("R2", "dma_gnt held", dma_gnt_o, 1'b1);
      if (!cf) cpu_req_i = 1'b0;
      dma_done_i = 1'b1;
      @(negedge clk_i);
      chk("R2", "dma_gnt released", dma_gnt_o, 1'b0);
      chk("R9", "busy released", busy_o, 1'b0);
      chk("R7", "stalled cpu after done", cpu_gnt_o, cf);
      dma_done_i = 1'b0; cpu_req_i = 1'b0;
      @(negedge clk_i);
      chk("R10", "cpu_wait idle", cpu_wait_o, 1'b0);
    end

    // both ports at the same free edge
    for (int s = 0; s < 4; s++) for (int d = 0; d < 4; d++) for (int c = 0; c < 4; c++) begin
      logic cf;
      cf = conf(c, s, d);
      @(negedge clk_i);
      dma_req_i = 1'b1; dma_src_i = 2'(s); dma_dst_i = 2'(d);
      cpu_req_i = 1'b1; cpu_region_i = 2'(c);
      @(negedge clk_i);
      chk("R3", "dma wins", dma_gnt_o, 1'b1);
      chk("R3", "cpu_gnt on contention", cpu_gnt_o, !cf);
      chk("R10", "cpu_wait on contention", cpu_wait_o, cf);
      chk("R10", "dma_wait on contention", dma_wait_o, 1'b0);
      dma_req_i = 1'b0;
      if (!cf) cpu_req_i = 1'b0;
      dma_done_i = 1'b1;
      @(negedge clk_i);
      chk("R7", "cpu after contention", cpu_gnt_o, cf);
      dma_done_i = 1'b0; cpu_req_i = 1'b0;
      @(negedge clk_i);
    end

    // done with a new conflicting request pending: CPU keeps waiting
    @(negedge clk_i);
    dma_req_i = 1'b1; dma_src_i = 2'b11; dma_dst_i = 2'b10;
    @(negedge clk_i);
    dma_req_i = 1'b0; cpu_req_i = 1'b1; cpu_region_i = 2'b10;
    @(negedge clk_i);
    chk("R4", "pio stalled", cpu_wait_o, 1'b1);
    dma_done_i = 1'b1; dma_req_i = 1'b1; dma_src_i = 2'b10; dma_dst_i = 2'b01;
    @(negedge clk_i);
    chk("R7", "pending dma keeps cpu waiting", cpu_wait_o, 1'b1);
    chk("R7", "pending dma accepted", dma_gnt_o, 1'b1);
    dma_done_i = 1'b0; dma_req_i = 1'b0;
    @(negedge clk_i);
    chk("R7", "still waiting", cpu_gnt_o, 1'b0);
    dma_done_i = 1'b1;
    @(negedge clk_i);
    chk("R7", "granted after last done", cpu_gnt_o, 1'b1);
    dma_done_i = 1'b0; cpu_req_i = 1'b0;
    @(negedge clk_i);

    // starvation: 8 chained stalling cycles, then the CPU wins once
    dma_req_i = 1'b1; dma_src_i = 2'b00; dma_dst_i = 2'b01;
    @(negedge clk_i);
    dma_req_i = 1'b0; cpu_req_i = 1'b1; cpu_region_i = 2'b11;
    @(negedge clk_i);
    for (int k = 1; k <= 9; k++) begin
      dma_done_i = 1'b1; dma_req_i = 1'b1;
      @(negedge clk_i);
      dma_done_i = 1'b0;
      if (k <= 8) begin
        chk("R8", "chained dma accepted", dma_gnt_o, 1'b1);
        chk("R8", "cpu still waiting", cpu_wait_o, 1'b1);
        dma_req_i = 1'b0;
        @(negedge clk_i);
      end else begin
        chk("R8", "cpu released", cpu_gnt_o, 1'b1);
        chk("R8", "dma held off", dma_gnt_o, 1'b0);
        chk("R10", "dma_wait on starve", dma_wait_o, 1'b1);
        cpu_req_i = 1'b0;
        @(negedge clk_i);
        chk("R8", "dma accepted after cpu", dma_gnt_o, 1'b1);
        chk("R8", "cpu grant single", cpu_gnt_o, 1'b0);
        dma_req_i = 1'b0; dma_done_i = 1'b1;
        @(negedge clk_i);
        dma_done_i = 1'b0;
      end
    end

    // asynchronous reset in the middle of a cycle
    @(negedge clk_i);
    dma_req_i = 1'b1;
    @(negedge clk_i);
    dma_req_i = 1'b0;
    chk("R9", "busy before reset", busy_o, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk("R1", "dma_gnt in reset", dma_gnt_o, 1'b0);
    chk("R1", "busy in reset", busy_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule